// File: doc/BRIEF.md
# Sleep Control Register with Sleep-Request Sequencer

This block is a 16-bit power-management control register behind a single port. Software writes it to start a sleep transition: when a write carries the sleep-enable bit, the block decodes a three-bit sleep type and emits a one-cycle request pulse. The pulse is a power-off request, a suspend-to-RAM request, or a suspend-to-disk indication. A suspend-to-disk indication is always followed, one cycle later, by a power-off request. The sleep-enable bit acts only as a trigger and is never stored, so reads always return it as zero.

The same register holds the SCI-enable bit. Two strobes from the platform set or clear that bit. The three-bit sleep-type code that means suspend-to-disk is sampled from an input while reset is asserted, so one design serves platforms that use different codes. Byte-lane enables allow either half of the register to be written alone.

The sequencer has five states. `ST_IDLE` emits nothing. `ST_OFF` drives the power-off pulse. `ST_RAM` drives the suspend pulse. `ST_DISK` drives the disk indication. `ST_TAIL` drives the power-off pulse that closes a disk sequence. Transitions:
- From `ST_IDLE`, `ST_OFF`, `ST_RAM` or `ST_TAIL`, a write that decodes to a sleep command moves to `ST_OFF`, `ST_RAM` or `ST_DISK`. Any other cycle returns to `ST_IDLE`.
- `ST_DISK` always moves to `ST_TAIL`.

Top module: `pm_sleep_ctl`

## Requirements
- R1: Reset clears the register to 0x0000, and no request pulse is driven while reset is asserted or in the first cycle after it.
- R2: A write stores the merged value with bit 13 (sleep-enable) forced to 0, and `rd_data_o` shows the stored value from the cycle after the write edge.
- R3: Byte enable bit 0 selects data bits 7:0 and byte enable bit 1 selects bits 15:8. A lane that is not enabled keeps its stored bits. The sleep decode uses the merged 16-bit value, so a write to the low byte alone can never trigger a sleep action.
- R4: A write whose merged value has bit 13 set and sleep type (bits 12:10) equal to 0 drives `off_req_o` high for exactly the one cycle after the write edge.
- R5: A write with bit 13 set and sleep type 1 drives `ram_req_o` high for exactly the one cycle after the write edge.
- R6: A write with bit 13 set and a sleep type of 2 or more that equals the latched S4 code drives `disk_req_o` for the one cycle after the write edge, then `off_req_o` for the following cycle.
- R7: A write with bit 13 clear, or with a sleep type of 2 or more that differs from the latched S4 code, produces no pulse.
- R8: `sci_set_i` sets bit 0 and `sci_clr_i` clears it. When both are high, set wins. Either strobe overrides bit 0 of a write in the same cycle.
- R9: The S4 code is sampled from `s4_code_i` only while reset is asserted. Changes to that input after reset have no effect until the next reset.
- R10: A sleep write whose edge falls in the `ST_DISK` cycle triggers nothing, although it still updates the register.
- R11: At most one of the three request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the S4 code is sampled while it is low |
| s4_code_i | input | 3 | Sleep-type code that means suspend-to-disk |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 2 | Byte-lane enables for the write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Stored register value |
| sci_set_i | input | 1 | Strobe that sets the SCI-enable bit |
| sci_clr_i | input | 1 | Strobe that clears the SCI-enable bit |
| off_req_o | output | 1 | One-cycle power-off request |
| ram_req_o | output | 1 | One-cycle suspend-to-RAM request |
| disk_req_o | output | 1 | One-cycle suspend-to-disk indication |

## Verification
The checker tests several properties in every cycle:
- the request outputs are mutually exclusive;
- bit 13 never reads back as set;
- every disk indication is followed by a power-off pulse and never by a suspend pulse;
- pulses last one cycle unless a new write follows;
- the SCI strobes take effect one cycle later.

Some behaviour depends on values, so only the bench scenarios can show it:
- which sleep type maps to which request;
- the effect of the latched S4 code, and the fact that it ignores the live input after reset;
- byte-lane merging, including a high-byte write that triggers a sleep;
- readback of exact register contents.

// File: rtl/pm_sleep_ctl_pkg.sv
package pm_sleep_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF,
        ST_RAM,
        ST_DISK,
        ST_TAIL
    } slp_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_OFF,
        CMD_RAM,
        CMD_DISK
    } slp_cmd_e;

endpackage

// File: rtl/pm_sleep_ctl_merge.sv
module pm_sleep_ctl_merge #(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0]   cur_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [REG_W/8-1:0] be_i,
    output logic [REG_W-1:0]   merged_o
);
    localparam int LANES = REG_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*8 +: 8] = be_i[g] ? wdata_i[g*8 +: 8] : cur_i[g*8 +: 8];
    end

endmodule

// File: rtl/pm_sleep_ctl_decode.sv
module pm_sleep_ctl_decode
    import pm_sleep_ctl_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int EN_BIT  = 13,
    parameter int TYP_LSB = 10,
    parameter int TYP_W   = 3
) (
    input  logic             valid_i,
    input  logic [REG_W-1:0] value_i,
    input  logic [TYP_W-1:0] s4_code_i,
    output slp_cmd_e         cmd_o
);
    logic [TYP_W-1:0] typ;

    assign typ = value_i[TYP_LSB +: TYP_W];

    always_comb begin
        cmd_o = CMD_NONE;
        if (valid_i && value_i[EN_BIT]) begin
            if (typ == TYP_W'(0)) begin
                cmd_o = CMD_OFF;
            end else if (typ == TYP_W'(1)) begin
                cmd_o = CMD_RAM;
            end else if (typ == s4_code_i) begin
                cmd_o = CMD_DISK;
            end
        end
    end

endmodule

// File: rtl/pm_sleep_ctl_store.sv
module pm_sleep_ctl_store #(
    parameter int REG_W   = 16,
    parameter int EN_BIT  = 13,
    parameter int SCI_BIT = 0,
    parameter int TYP_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] merged_i,
    input  logic             sci_set_i,
    input  logic             sci_clr_i,
    input  logic [TYP_W-1:0] s4_in_i,
    output logic [REG_W-1:0] value_o,
    output logic [TYP_W-1:0] s4_q_o
);
    localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << EN_BIT);

    logic [REG_W-1:0] val_q;
    logic [REG_W-1:0] val_d;
    logic [TYP_W-1:0] s4_q;

    always_comb begin
        val_d = val_q;
        if (wr_en_i) begin
            val_d = merged_i & KEEP_MASK;
        end
        if (sci_set_i) begin
            val_d[SCI_BIT] = 1'b1;
        end else if (sci_clr_i) begin
            val_d[SCI_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            s4_q  <= s4_in_i;
        end else begin
            val_q <= val_d;
        end
    end

    assign value_o = val_q;
    assign s4_q_o  = s4_q;

endmodule

// File: rtl/pm_sleep_ctl_fsm.sv
module pm_sleep_ctl_fsm
    import pm_sleep_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  slp_cmd_e cmd_i,
    output logic     off_o,
    output logic     ram_o,
    output logic     disk_o
);
    slp_state_e state_q;
    slp_state_e state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_DISK: state_d = ST_TAIL;
            ST_IDLE, ST_OFF, ST_RAM, ST_TAIL: begin
                unique case (cmd_i)
                    CMD_OFF:  state_d = ST_OFF;
                    CMD_RAM:  state_d = ST_RAM;
                    CMD_DISK: state_d = ST_DISK;
                    CMD_NONE: state_d = ST_IDLE;
                    default:  state_d = ST_IDLE;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        off_o  = 1'b0;
        ram_o  = 1'b0;
        disk_o = 1'b0;
        unique case (state_q)
            ST_OFF, ST_TAIL: off_o  = 1'b1;
            ST_RAM:          ram_o  = 1'b1;
            ST_DISK:         disk_o = 1'b1;
            ST_IDLE:         ;
            default:         ;
        endcase
    end

endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
    import pm_sleep_ctl_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int EN_BIT  = 13,
    parameter int TYP_LSB = 10,
    parameter int TYP_W   = 3,
    parameter int SCI_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TYP_W-1:0]   s4_code_i,
    input  logic               wr_en_i,
    input  logic [REG_W/8-1:0] wr_be_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic               sci_set_i,
    input  logic               sci_clr_i,
    output logic               off_req_o,
    output logic               ram_req_o,
    output logic               disk_req_o
);
    logic [REG_W-1:0] cur_val;
    logic [REG_W-1:0] merged;
    logic [TYP_W-1:0] s4_q;
    slp_cmd_e         cmd;

    pm_sleep_ctl_merge #(.REG_W(REG_W)) u_merge (
        .cur_i    (cur_val),
        .wdata_i  (wr_data_i),
        .be_i     (wr_be_i),
        .merged_o (merged)
    );

    pm_sleep_ctl_decode #(
        .REG_W(REG_W), .EN_BIT(EN_BIT), .TYP_LSB(TYP_LSB), .TYP_W(TYP_W)
    ) u_decode (
        .valid_i   (wr_en_i),
        .value_i   (merged),
        .s4_code_i (s4_q),
        .cmd_o     (cmd)
    );

    pm_sleep_ctl_store #(
        .REG_W(REG_W), .EN_BIT(EN_BIT), .SCI_BIT(SCI_BIT), .TYP_W(TYP_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .merged_i  (merged),
        .sci_set_i (sci_set_i),
        .sci_clr_i (sci_clr_i),
        .s4_in_i   (s4_code_i),
        .value_o   (cur_val),
        .s4_q_o    (s4_q)
    );

    pm_sleep_ctl_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .off_o  (off_req_o),
        .ram_o  (ram_req_o),
        .disk_o (disk_req_o)
    );

    assign rd_data_o = cur_val;

endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk #(
    parameter int REG_W   = 16,
    parameter int EN_BIT  = 13,
    parameter int SCI_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             sci_set_i,
    input logic             sci_clr_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             off_req_o,
    input logic             ram_req_o,
    input logic             disk_req_o
);
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({off_req_o, ram_req_o, disk_req_o})); // R11

    AST_SLP_EN_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[EN_BIT]); // R2

    AST_DISK_THEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        disk_req_o |=> (off_req_o && !disk_req_o)); // R6

    AST_NO_SUSPEND_AFTER_DISK: assert property (@(posedge clk) disable iff (!rst_n)
        disk_req_o |=> !ram_req_o); // R10

    AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req_o && !wr_en_i) |=> !off_req_o); // R4

    AST_RAM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req_o && !wr_en_i) |=> !ram_req_o); // R5

    AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req_o || disk_req_o) |-> $past(wr_en_i)); // R7

    AST_SCI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sci_set_i |=> rd_data_o[SCI_BIT]); // R8

    AST_SCI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_clr_i && !sci_set_i) |=> !rd_data_o[SCI_BIT]); // R8

endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk #(
    .REG_W(REG_W), .EN_BIT(EN_BIT), .SCI_BIT(SCI_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .sci_set_i  (sci_set_i),
    .sci_clr_i  (sci_clr_i),
    .rd_data_o  (rd_data_o),
    .off_req_o  (off_req_o),
    .ram_req_o  (ram_req_o),
    .disk_req_o (disk_req_o)
);

// File: tb/pm_sleep_ctl_bench.sv
`timescale 1ns/1ps
module pm_sleep_ctl_bench;

    localparam int K_NONE = 0;
    localparam int K_OFF  = 1;
    localparam int K_RAM  = 2;
    localparam int K_DISK = 3;

    typedef struct packed {
        int unsigned cyc;
        logic [2:0]  vec;   // {off, ram, disk}
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  s4_code = 3'd3;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        sci_set = 1'b0;
    logic        sci_clr = 1'b0;
    logic        off_req, ram_req, disk_req;

    int unsigned cyc = 0;
    int          n_vec = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    exp_t        sb_q[$];

    pm_sleep_ctl u_pm_sleep_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s4_code_i  (s4_code),
        .wr_en_i    (wr_en),
        .wr_be_i    (wr_be),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .sci_set_i  (sci_set),
        .sci_clr_i  (sci_clr),
        .off_req_o  (off_req),
        .ram_req_o  (ram_req),
        .disk_req_o (disk_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops scoreboard entries and compares the pulse outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] exp_v;
            logic [2:0] act_v;
            exp_v = 3'b000;
            if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
                exp_v = sb_q[0].vec;
                void'(sb_q.pop_front());
            end
            act_v = {off_req, ram_req, disk_req};
            n_vec++;
            if (act_v !== exp_v) begin
                n_fail++;
                $display("FAIL R4/R5/R6/R7/R10/R11 pulses cycle %0d actual %b expected %b",
                         cyc, act_v, exp_v);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: called at a negedge; pushes the expected pulses, then applies the write
    task automatic wr(input logic [1:0] be, input logic [15:0] d, input int kind,
                      input logic set, input logic clr);
        exp_t e;
        if (kind == K_OFF) begin
            e.cyc = cyc + 1; e.vec = 3'b100; sb_q.push_back(e);
        end else if (kind == K_RAM) begin
            e.cyc = cyc + 1; e.vec = 3'b010; sb_q.push_back(e);
        end else if (kind == K_DISK) begin
            e.cyc = cyc + 1; e.vec = 3'b001; sb_q.push_back(e);
            e.cyc = cyc + 2; e.vec = 3'b100; sb_q.push_back(e);
        end
        wr_en = 1'b1; wr_be = be; wr_data = d; sci_set = set; sci_clr = clr;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0000; sci_set = 1'b0; sci_clr = 1'b0;
    endtask

    task automatic strobe(input logic set, input logic clr);
        sci_set = set; sci_clr = clr;
        @(posedge clk);
        @(negedge clk);
        sci_set = 1'b0; sci_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] code);
        rst_n = 1'b0;
        s4_code = code;
        repeat (3) @(negedge clk);
        chk("R1 register during reset", rd_data, 16'h0000);
        chk("R1 pulses during reset", {13'd0, off_req, ram_req, disk_req}, 16'h0000);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3'd3);
        idle(1);
        chk("R1 register after reset", rd_data, 16'h0000);

        wr(2'b11, 16'h00A5, K_NONE, 0, 0);
        chk("R2 plain write readback", rd_data, 16'h00A5);
        wr(2'b11, 16'h2055, K_OFF, 0, 0);
        chk("R2 R4 type0 sleep-enable dropped", rd_data, 16'h0055);
        idle(2);
        wr(2'b11, 16'h2400, K_RAM, 0, 0);
        chk("R5 type1 readback", rd_data, 16'h0400);
        idle(2);

        // R6 with back-to-back R10 write landing on the disk cycle
        wr(2'b11, 16'h2C00, K_DISK, 0, 0);
        chk("R6 type3 readback", rd_data, 16'h0C00);
        wr(2'b11, 16'h2401, K_NONE, 0, 0);
        chk("R10 ignored write still stored", rd_data, 16'h0401);
        idle(3);

        wr(2'b11, 16'h3400, K_NONE, 0, 0);
        chk("R7 type5 not S4", rd_data, 16'h1400);
        wr(2'b11, 16'h2800, K_NONE, 0, 0);
        chk("R7 type2 not S4", rd_data, 16'h0800);
        wr(2'b11, 16'h0400, K_NONE, 0, 0);
        chk("R7 no sleep-enable", rd_data, 16'h0400);
        idle(2);

        wr(2'b01, 16'h0033, K_NONE, 0, 0);
        chk("R3 low lane only", rd_data, 16'h0433);
        wr(2'b10, 16'h24FF, K_RAM, 0, 0);
        chk("R3 high lane triggers merged decode", rd_data, 16'h0433);
        idle(2);
        wr(2'b01, 16'hFFFF, K_NONE, 0, 0);
        chk("R3 low lane cannot trigger", rd_data, 16'h04FF);
        idle(2);

        strobe(0, 1);
        chk("R8 clear strobe", rd_data, 16'h04FE);
        strobe(1, 0);
        chk("R8 set strobe", rd_data, 16'h04FF);
        strobe(0, 1);
        strobe(1, 1);
        chk("R8 set wins over clear", rd_data, 16'h04FF);
        wr(2'b11, 16'h0010, K_NONE, 1, 0);
        chk("R8 set overrides written bit0", rd_data, 16'h0011);
        wr(2'b11, 16'h0011, K_NONE, 0, 1);
        chk("R8 clear overrides written bit0", rd_data, 16'h0010);

        s4_code = 3'd6;
        wr(2'b11, 16'h3800, K_NONE, 0, 0);
        chk("R9 live code ignored", rd_data, 16'h1800);
        idle(2);
        wr(2'b11, 16'h2C00, K_DISK, 0, 0);
        chk("R9 latched code still used", rd_data, 16'h0C00);
        idle(3);

        do_reset(3'd6);
        idle(1);
        chk("R1 cleared by second reset", rd_data, 16'h0000);
        wr(2'b11, 16'h3800, K_DISK, 0, 0);
        chk("R9 new code after reset", rd_data, 16'h1800);
        idle(3);
        wr(2'b11, 16'h2C00, K_NONE, 0, 0);
        chk("R9 old code dropped", rd_data, 16'h0C00);
        idle(2);
        wr(2'b11, 16'h2000, K_OFF, 0, 0);
        chk("R4 type0 after reset", rd_data, 16'h0000);
        idle(3);

        chk("scoreboard drained", 16'(sb_q.size()), 16'h0000);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule